// File: doc/BRIEF.md
# DMA Channel Register File and Control

This block holds the programming and progress registers of one bus-master DMA channel that works next to a SCSI protocol engine. Software loads a start count, a start address and a start list address, then writes a command word. The command's low two bits choose an action: going idle, blast, abort, or start. A start loads the working registers from the start registers and raises the DMA-enable output. An abort sends a one-cycle request to the protocol engine. An idle command drops DMA-enable.

While the channel runs, the memory mover asks for one burst at a time by giving a length and a direction. The block grants a length cut down to the working count, refuses a burst whose direction disagrees with the command, and moves the working count and working address on by the granted amount. A command-complete input ends the transfer. The status word has two clearing modes, chosen by a separate input: write-one-to-clear, or clear-after-read. The protocol engine's interrupt line is merged into the status word live whenever it is read.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the registers read as follows: command 0, start count, start address and start list address 0, working count 0, working address 0xFFFFFFFF, status 0, working list address 0xFFFFFFFD. After reset, `dma_en` and `abort_req` are low.
- R2: The register offsets are: 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start list address, 7 working list address. Offsets 0, 1, 2 and 6 are written directly, and offset 5 is written as described in R8 and R9. Writes to offsets 3, 4 and 7 are dropped. The command register keeps bits [7:0], and bits above that read as zero. `reg_rdata` shows the addressed register combinationally.
- R3: A command write with bits [1:0] = 3 (start) does the following at that clock edge: it copies start count into working count, start address into working address and start list address into working list address; it clears status bits [5:0]; it sets `dma_en`.
- R4: Command bits [1:0] = 0 (idle) clear `dma_en`. Bits [1:0] = 2 (abort) drive `abort_req` high for exactly the one cycle after the write. Bits [1:0] = 1 (blast) change neither output. Every command write triggers its action again, even when it repeats the stored value.
- R5: Command bit 7 set means device-to-memory, and `xfer_dir` = 1 means the same. A burst request whose direction differs from command bit 7 gets a grant of 0, and the working registers do not change.
- R6: For a burst request with the matching direction, `xfer_grant` is the smaller of `xfer_len` and the working count, in the same cycle. At the next edge the working count drops by the grant and the working address rises by it.
- R7: `cmd_done` sets status bit 3 (done) and sets the working count to 0. It takes priority over a burst in the same cycle, but the working address still advances.
- R8: Status bits are 0 power-down, 1 error, 2 abort, 3 done, 4 SCSI interrupt and 5 blast complete. With `clr_on_read` low, writing ones to status bits 1 to 3 clears those bits and leaves the others unchanged.
- R9: With `clr_on_read` high, writes to status are ignored. A status read returns the current value, and bits 1 to 3 are cleared at that edge.
- R10: A status read shows bit 4 set whenever `core_irq` is high, whatever the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for clear-after-read) |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the addressed register |
| clr_on_read | input | 1 | 1: status clears after read; 0: write-one-to-clear |
| core_irq | input | 1 | Protocol engine interrupt level |
| cmd_done | input | 1 | Command-complete pulse |
| xfer_req | input | 1 | Burst request |
| xfer_dir | input | 1 | Burst direction, 1 = device-to-memory |
| xfer_len | input | DW | Requested burst length |
| xfer_grant | output | DW | Granted burst length |
| dma_en | output | 1 | DMA enabled |
| abort_req | output | 1 | One-cycle abort request |

## Verification
Read data and burst grants are combinational, so the bench checks them 1 ns after it drives the inputs, well before the next rising edge. Register updates, `dma_en` and `abort_req` take effect at the rising edge, so the bench checks them at the following falling edge, one cycle after the stimulus. The clear-after-read case is checked by reading status twice in a row: the first read must return the value before the clear and the second read the cleared value. A burst that arrives together with command-complete is checked by reading the working count in the next cycle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int unsigned NREG  = 8;
   localparam int unsigned AW    = $clog2(NREG);

   localparam logic [AW-1:0] OFS_CMD  = 3'd0;
   localparam logic [AW-1:0] OFS_SCNT = 3'd1;
   localparam logic [AW-1:0] OFS_SADR = 3'd2;
   localparam logic [AW-1:0] OFS_WCNT = 3'd3;
   localparam logic [AW-1:0] OFS_WADR = 3'd4;
   localparam logic [AW-1:0] OFS_STAT = 3'd5;
   localparam logic [AW-1:0] OFS_SLST = 3'd6;
   localparam logic [AW-1:0] OFS_WLST = 3'd7;

   localparam int unsigned CMD_W   = 8;
   localparam int unsigned CMD_DIR = 7;

   localparam int unsigned ST_W    = 6;
   localparam int unsigned ST_DONE = 3;
   localparam int unsigned ST_IRQ  = 4;
   localparam logic [ST_W-1:0] ST_CLRABLE = 6'b001110;

   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_BLAST = 2'd1,
      ACT_ABORT = 2'd2,
      ACT_START = 2'd3
   } act_e;

   typedef struct packed {
      logic idle;
      logic blast;
      logic abort;
      logic start;
   } act_pulse_t;
endpackage

// File: rtl/dmac_cmd_decode.sv
module dmac_cmd_decode
   import dmac_pkg::*;
(
   input  logic       wr_cmd,
   input  logic [1:0] code,
   output act_pulse_t act
);
   always_comb begin
      act = '0;
      if (wr_cmd) begin
         unique case (act_e'(code))
            ACT_IDLE:  act.idle  = 1'b1;
            ACT_BLAST: act.blast = 1'b1;
            ACT_ABORT: act.abort = 1'b1;
            ACT_START: act.start = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/dmac_burst.sv
module dmac_burst #(
   parameter int unsigned DW = 32
) (
   input  logic          req,
   input  logic          dir,
   input  logic          cmd_dir,
   input  logic [DW-1:0] len,
   input  logic [DW-1:0] wcnt,
   output logic [DW-1:0] grant,
   output logic          fire
);
   logic          dir_ok;
   logic [DW-1:0] clipped;

   assign dir_ok  = req && (dir == cmd_dir);
   assign clipped = (len > wcnt) ? wcnt : len;
   assign grant   = dir_ok ? clipped : '0;
   assign fire    = dir_ok;
endmodule

// File: rtl/dmac_status.sv
module dmac_status
   import dmac_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            done_set,
   input  logic [ST_W-1:0] clr_mask,
   output logic [ST_W-1:0] st_q
);
   logic [ST_W-1:0] set_mask;

   assign set_mask = done_set ? ST_W'(1 << ST_DONE) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)     st_q <= '0;
      else if (start) st_q <= '0;
      else            st_q <= (st_q & ~clr_mask) | set_mask;
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dmac_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [2:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          clr_on_read,
   input  logic          core_irq,
   input  logic          cmd_done,
   input  logic          xfer_req,
   input  logic          xfer_dir,
   input  logic [DW-1:0] xfer_len,
   output logic [DW-1:0] xfer_grant,
   output logic          dma_en,
   output logic          abort_req
);
   localparam logic [DW-1:0] WADR_RST = '1;
   localparam logic [DW-1:0] WLST_RST = ~DW'(2);

   if (DW < 16) begin : g_dw_check
      $error("dma_chan_regs: DW must be at least 16");
   end

   logic [CMD_W-1:0] cmd_q;
   logic [DW-1:0]    scnt_q, sadr_q, slst_q;
   logic [DW-1:0]    wcnt_q, wadr_q, wlst_q;
   logic [ST_W-1:0]  st_q;
   logic [ST_W-1:0]  clr_mask;
   logic             burst_fire;
   act_pulse_t       act;

   logic wr_cmd, wr_stat, rd_stat;
   assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
   assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
   assign rd_stat = reg_rd && (reg_addr == OFS_STAT);

   dmac_cmd_decode u_dec (
      .wr_cmd (wr_cmd),
      .code   (reg_wdata[1:0]),
      .act    (act)
   );

   dmac_burst #(.DW(DW)) u_burst (
      .req     (xfer_req),
      .dir     (xfer_dir),
      .cmd_dir (cmd_q[CMD_DIR]),
      .len     (xfer_len),
      .wcnt    (wcnt_q),
      .grant   (xfer_grant),
      .fire    (burst_fire)
   );

   always_comb begin
      clr_mask = '0;
      if (wr_stat && !clr_on_read)     clr_mask = reg_wdata[ST_W-1:0] & ST_CLRABLE;
      else if (rd_stat && clr_on_read) clr_mask = ST_CLRABLE;
   end

   dmac_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (act.start),
      .done_set (cmd_done),
      .clr_mask (clr_mask),
      .st_q     (st_q)
   );

   // programmed registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         scnt_q <= '0;
         sadr_q <= '0;
         slst_q <= '0;
      end else if (reg_wr) begin
         unique case (reg_addr)
            OFS_CMD:  cmd_q  <= reg_wdata[CMD_W-1:0];
            OFS_SCNT: scnt_q <= reg_wdata;
            OFS_SADR: sadr_q <= reg_wdata;
            OFS_SLST: slst_q <= reg_wdata;
            default:  ;
         endcase
      end
   end

   // working registers: start > complete > burst
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt_q <= '0;
         wadr_q <= WADR_RST;
         wlst_q <= WLST_RST;
      end else if (act.start) begin
         wcnt_q <= scnt_q;
         wadr_q <= sadr_q;
         wlst_q <= slst_q;
      end else begin
         if (cmd_done)        wcnt_q <= '0;
         else if (burst_fire) wcnt_q <= wcnt_q - xfer_grant;
         if (burst_fire)      wadr_q <= wadr_q + xfer_grant;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dma_en    <= 1'b0;
         abort_req <= 1'b0;
      end else begin
         abort_req <= act.abort;
         if (act.start)     dma_en <= 1'b1;
         else if (act.idle) dma_en <= 1'b0;
      end
   end

   always_comb begin
      unique case (reg_addr)
         OFS_CMD:  reg_rdata = DW'(cmd_q);
         OFS_SCNT: reg_rdata = scnt_q;
         OFS_SADR: reg_rdata = sadr_q;
         OFS_WCNT: reg_rdata = wcnt_q;
         OFS_WADR: reg_rdata = wadr_q;
         OFS_STAT: reg_rdata = DW'(st_q | (core_irq ? ST_W'(1 << ST_IRQ) : '0));
         OFS_SLST: reg_rdata = slst_q;
         default:  reg_rdata = wlst_q;
      endcase
   end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
   parameter int unsigned DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [2:0]    reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic [DW-1:0] reg_rdata,
   input logic          clr_on_read,
   input logic          core_irq,
   input logic          cmd_done,
   input logic          xfer_req,
   input logic          xfer_dir,
   input logic [DW-1:0] xfer_grant,
   input logic          dma_en,
   input logic          abort_req,
   input logic [7:0]    cmd_q,
   input logic [DW-1:0] scnt_q,
   input logic [DW-1:0] wcnt_q,
   input logic [5:0]    st_q
);
   logic start_w;
   assign start_w = reg_wr && reg_addr == 3'd0 && reg_wdata[1:0] == 2'd3;

   a_r3_start_copy: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> (wcnt_q == $past(scnt_q) && dma_en && st_q == 6'd0));

   a_r4_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |-> $past(reg_wr && reg_addr == 3'd0 && reg_wdata[1:0] == 2'd2));

   a_r5_dir_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_dir != cmd_q[7]) |-> xfer_grant == '0);

   a_r6_grant_clip: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_grant <= wcnt_q);

   a_r7_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && !start_w) |=> (wcnt_q == '0 && st_q[3]));

   a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd5 && clr_on_read && !reg_rd && !cmd_done) |=> $stable(st_q));

   a_r10_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd5 && core_irq) |-> reg_rdata[4]);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_rd      (reg_rd),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .clr_on_read (clr_on_read),
   .core_irq    (core_irq),
   .cmd_done    (cmd_done),
   .xfer_req    (xfer_req),
   .xfer_dir    (xfer_dir),
   .xfer_grant  (xfer_grant),
   .dma_en      (dma_en),
   .abort_req   (abort_req),
   .cmd_q       (cmd_q),
   .scnt_q      (scnt_q),
   .wcnt_q      (wcnt_q),
   .st_q        (st_q)
);

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        clr_on_read = 1'b0, core_irq = 1'b0, cmd_done = 1'b0;
   logic        xfer_req = 1'b0, xfer_dir = 1'b0;
   logic [31:0] xfer_len = '0, xfer_grant;
   logic        dma_en, abort_req;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // model state
   logic [31:0] m_cmd, m_sc, m_sa, m_sl, m_wc, m_wa, m_wl, m_st;
   bit          m_en, m_abort;

   always #2.5 clk = ~clk;

   dma_chan_regs uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .clr_on_read(clr_on_read), .core_irq(core_irq), .cmd_done(cmd_done),
      .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_len(xfer_len),
      .xfer_grant(xfer_grant), .dma_en(dma_en), .abort_req(abort_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [2:0] a, input bit irq);
      case (a)
         3'd0: exp_read = m_cmd;
         3'd1: exp_read = m_sc;
         3'd2: exp_read = m_sa;
         3'd3: exp_read = m_wc;
         3'd4: exp_read = m_wa;
         3'd5: exp_read = m_st | (irq ? 32'h10 : 32'h0);
         3'd6: exp_read = m_sl;
         default: exp_read = m_wl;
      endcase
   endfunction

   function automatic logic [31:0] exp_grant(input bit xd, input logic [31:0] xl);
      if (xd != m_cmd[7]) return 32'h0;
      return (xl > m_wc) ? m_wc : xl;
   endfunction

   task automatic reset_model();
      m_cmd = 0; m_sc = 0; m_sa = 0; m_sl = 0; m_wc = 0;
      m_wa = 32'hFFFF_FFFF; m_wl = 32'hFFFF_FFFD; m_st = 0;
      m_en = 0; m_abort = 0;
   endtask

   // one cycle: entered and left at a falling edge
   task automatic cyc(input bit wr, input bit rd, input logic [2:0] a, input logic [31:0] d,
                      input bit xr, input bit xd, input logic [31:0] xl,
                      input bit dn, input bit irq, input bit cor, input string tag);
      logic [31:0] g, clr;
      bit fire, startw;
      chk("R4 abort_req", {31'b0, abort_req}, {31'b0, m_abort});
      chk("R3 dma_en", {31'b0, dma_en}, {31'b0, m_en});
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
      xfer_req = xr; xfer_dir = xd; xfer_len = xl;
      cmd_done = dn; core_irq = irq; clr_on_read = cor;
      #1;
      g = xr ? exp_grant(xd, xl) : 32'h0;
      fire = xr && (xd == m_cmd[7]);
      if (xr) chk(fire ? "R6 grant" : "R5 grant", xfer_grant, g);
      if (rd) chk(tag, reg_rdata, exp_read(a, irq));
      startw = wr && a == 3'd0 && d[1:0] == 2'd3;
      clr = 0;
      if (wr && a == 3'd5 && !cor) clr = d & 32'hE;
      else if (rd && a == 3'd5 && cor) clr = 32'hE;
      if (startw) begin
         m_st = 0; m_wc = m_sc; m_wa = m_sa; m_wl = m_sl;
      end else begin
         m_st = (m_st & ~clr) | (dn ? 32'h8 : 32'h0);
         if (dn) m_wc = 0; else if (fire) m_wc = m_wc - g;
         if (fire) m_wa = m_wa + g;
      end
      if (wr) begin
         case (a)
            3'd0: begin
               m_cmd = d & 32'hFF;
               if (d[1:0] == 2'd3) m_en = 1;
               else if (d[1:0] == 2'd0) m_en = 0;
            end
            3'd1: m_sc = d;
            3'd2: m_sa = d;
            3'd6: m_sl = d;
            default: ;
         endcase
      end
      m_abort = wr && a == 3'd0 && d[1:0] == 2'd2;
      @(negedge clk);
      reg_wr = 0; reg_rd = 0; xfer_req = 0; cmd_done = 0;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d, input bit cor);
      cyc(1, 0, a, d, 0, 0, 0, 0, 0, cor, "");
   endtask

   task automatic rd_reg(input logic [2:0] a, input bit irq, input bit cor, input string tag);
      cyc(0, 1, a, 0, 0, 0, 0, 0, irq, cor, tag);
   endtask

   task automatic burst(input bit xd, input logic [31:0] xl, input bit dn);
      cyc(0, 0, 0, 0, 1, xd, xl, dn, 0, 0, "");
   endtask

   initial begin
      reset_model();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset values
      for (int i = 0; i < 8; i++) rd_reg(3'(i), 0, 0, "R1 reset value");
      // R3 start copies
      wr_reg(3'd1, 32'd100, 0);
      wr_reg(3'd2, 32'h1000, 0);
      wr_reg(3'd6, 32'h2000, 0);
      wr_reg(3'd0, 32'h83, 0);
      rd_reg(3'd3, 0, 0, "R3 working count");
      rd_reg(3'd4, 0, 0, "R3 working address");
      rd_reg(3'd7, 0, 0, "R3 working list");
      rd_reg(3'd5, 0, 0, "R3 status cleared");
      // R5/R6 bursts
      burst(1, 32'd30, 0);
      burst(0, 32'd10, 0);
      rd_reg(3'd3, 0, 0, "R5 count unchanged");
      burst(1, 32'd200, 0);
      rd_reg(3'd3, 0, 0, "R6 clipped count zero");
      rd_reg(3'd4, 0, 0, "R6 address advanced");
      // R7 complete with burst
      wr_reg(3'd0, 32'h83, 0);
      burst(1, 32'd10, 1);
      rd_reg(3'd3, 0, 0, "R7 count zero");
      rd_reg(3'd4, 0, 0, "R7 address advanced");
      rd_reg(3'd5, 0, 0, "R7 done set");
      // R8 write-one-to-clear
      wr_reg(3'd5, 32'h8, 0);
      rd_reg(3'd5, 0, 0, "R8 done cleared");
      // R9 clear-after-read
      burst(1, 32'd0, 1);
      wr_reg(3'd5, 32'hF, 1);
      rd_reg(3'd5, 0, 1, "R9 write ignored");
      rd_reg(3'd5, 0, 1, "R9 cleared by read");
      // R10 irq merge
      rd_reg(3'd5, 1, 0, "R10 irq bit");
      // R2 dropped writes
      wr_reg(3'd3, 32'h55, 0);
      wr_reg(3'd4, 32'h66, 0);
      wr_reg(3'd7, 32'h77, 0);
      rd_reg(3'd3, 0, 0, "R2 wcnt write dropped");
      rd_reg(3'd4, 0, 0, "R2 wadr write dropped");
      rd_reg(3'd7, 0, 0, "R2 wlst write dropped");
      wr_reg(3'd0, 32'hFFFF_FF81, 0);
      rd_reg(3'd0, 0, 0, "R2 command width");
      // R4 blast, abort twice, idle
      wr_reg(3'd0, 32'h81, 0);
      wr_reg(3'd0, 32'h82, 0);
      wr_reg(3'd0, 32'h82, 0);
      wr_reg(3'd0, 32'h80, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
      // random mix
      void'($urandom(32'd1234));
      for (int n = 0; n < 4000; n++) begin
         int sel;
         logic [2:0] a;
         logic [31:0] d;
         sel = $urandom_range(0, 9);
         a = 3'($urandom_range(0, 7));
         d = $urandom;
         if (a == 3'd1) d = $urandom_range(0, 300);
         if (a == 3'd0) d = {24'b0, d[7:0]};
         if (sel < 3)
            cyc(1, 0, a, d, $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 120), $urandom_range(0, 9) == 0, 0,
                $urandom_range(0, 1), "");
         else if (sel < 6)
            cyc(0, 1, a, 0, $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 120), $urandom_range(0, 9) == 0,
                $urandom_range(0, 1), $urandom_range(0, 1),
                (a == 3'd5) ? "R8 status read" : "R2 register read");
         else
            cyc(0, 0, 0, 0, 1, $urandom_range(0, 1), $urandom_range(0, 120),
                $urandom_range(0, 7) == 0, 0, 0, "");
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule